// File: doc/BRIEF.md
# Over-Current Fault Latch

This block holds the protection logic of a phase current sensor. A comparator outside the block raises a flag when the magnitude of the differential shunt voltage is above the trip level. The block debounces that flag. Once the flag has been high long enough, it latches an active-low fault output and tells the PWM output driver to release the shared PWM line, so that the line floats high through its pull-up.

The latched fault does not clear when the overload goes away. It clears only when something outside pulls the PWM line low for a minimum number of clock cycles. The width counter runs only while the block itself holds the driver released, so the block's own PWM low phases can never look like a reset request. If the overload is still present when the fault clears, the block waits for the next SYNC edge, rising or falling, and latches again at once, without a second debounce. Tying the fault pin to the PWM pin therefore gives automatic clearing: the asserted fault pulls the line low, the line clears the fault, and the fault comes back on the next SYNC edge for as long as the overload lasts.

All pins are plain control levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ocp_fault_latch`

## Requirements
- R1: After a synchronous reset, `fault_n_o` is 1 and `drive_off_o` is 0. This holds even if the fault was latched when reset arrived.
- R2: With `trip_i` sampled high on `DEB_CYC` consecutive rising clock edges, `fault_n_o` goes to 0 right after the last of those edges. After `DEB_CYC-1` such edges it is still 1.
- R3: Any edge at which `trip_i` is sampled low during debounce restarts the count from zero.
- R4: Once latched, `fault_n_o` stays 0 while the line is high, whatever `trip_i` does.
- R5: `drive_off_o` is 1 exactly while `fault_n_o` is 0.
- R6: The latched fault clears right after the edge that ends `CLR_CYC` consecutive samples of `line_i` low (0 = line low). A low pulse of `CLR_CYC-1` samples leaves it latched.
- R7: A low line while no fault is latched has no effect on the outputs. Low samples taken before the fault latched do not count towards clearing.
- R8: If `trip_i` is high at the clearing edge, the fault latches again on the next SYNC transition of either polarity. It appears `SYNC_STAGES+1` edges after the `sync_i` change, and no debounce is applied.
- R9: If `trip_i` drops after such a clear, the pending re-latch is cancelled. A new fault then needs a full debounce, and SYNC transitions alone never set the fault.
- R10: With `line_i` wired to `fault_n_o` (autoreset), the fault clears `CLR_CYC` edges after it latches and latches again on each SYNC transition while the overload lasts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| trip_i | input | 1 | Comparator flag: sense magnitude above trip level |
| sync_i | input | 1 | SYNC input, asynchronous to `clk` |
| line_i | input | 1 | Sensed level of the shared PWM line (0 = low) |
| fault_n_o | output | 1 | Fault output, active low |
| drive_off_o | output | 1 | Forces the PWM driver off while high |

## Verification
The assertions assume that `trip_i` and `line_i` are already synchronous to `clk`, because the block samples them directly. They also assume that SYNC levels last longer than the synchronizer depth, so that each transition gives a single clean edge pulse. The bench changes every input 1 ns after a rising edge. It holds `sync_i` for many cycles between transitions. In autoreset it feeds `line_i` from `fault_n_o` through a continuous wired connection, which models the external tie.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    OCP_ARMED   = 2'd0,
    OCP_LATCHED = 2'd1,
    OCP_REARM   = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_sync_edge.sv
module ocp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_i};
  end

  assign edge_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/ocp_run_count.sv
module ocp_run_count #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_i,
  input  logic cond_i,
  output logic hit_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold_i || !cond_i) cnt <= '0;
    else if (cnt != LAST)         cnt <= cnt + 1'b1;
  end

  assign hit_o = cond_i && !hold_i && (cnt == LAST);

  // R2 R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch #(
  parameter int DEB_CYC     = 350,
  parameter int CLR_CYC     = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trip_i,
  input  logic sync_i,
  input  logic line_i,
  output logic fault_n_o,
  output logic drive_off_o
);
  import ocp_pkg::*;

  ocp_state_e st, st_nx;
  logic sync_edge, deb_hit, clr_hit;
  logic deb_hold, clr_hold;

  assign deb_hold = (st != OCP_ARMED);
  assign clr_hold = (st != OCP_LATCHED);

  ocp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(sync_i), .edge_o(sync_edge));

  ocp_run_count #(.LEN(DEB_CYC)) u_deb (
    .clk(clk), .rst(rst), .hold_i(deb_hold), .cond_i(trip_i), .hit_o(deb_hit));

  ocp_run_count #(.LEN(CLR_CYC)) u_clr (
    .clk(clk), .rst(rst), .hold_i(clr_hold), .cond_i(!line_i), .hit_o(clr_hit));

  always_comb begin
    st_nx = st;
    unique case (st)
      OCP_ARMED:   if (deb_hit) st_nx = OCP_LATCHED;
      OCP_LATCHED: if (clr_hit) st_nx = trip_i ? OCP_REARM : OCP_ARMED;
      OCP_REARM: begin
        if (!trip_i)        st_nx = OCP_ARMED;
        else if (sync_edge) st_nx = OCP_LATCHED;
      end
      default:     st_nx = OCP_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= OCP_ARMED;
    else     st <= st_nx;
  end

  assign fault_n_o   = (st != OCP_LATCHED);
  assign drive_off_o = (st == OCP_LATCHED);

  // R2 R8
  set_source_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fault_n_o) |-> ($past(deb_hit) || $past(sync_edge)));

  // R6
  clear_source_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(fault_n_o) && !$past(rst)) |-> !$past(line_i));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fault_n_o && line_i) |=> !fault_n_o);

  // R9
  rearm_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (st == OCP_REARM && !trip_i) |=> fault_n_o);

  // R5
  drive_match_chk: assert property (@(posedge clk) disable iff (rst)
    drive_off_o != fault_n_o);
endmodule

// File: tb/ocp_fault_latch_test.sv
module ocp_fault_latch_test;
  localparam int DEB = 350;
  localparam int CLR = 40;
  localparam int STG = 2;

  logic clk = 0;
  logic rst = 1;
  logic trip = 0;
  logic sync_drv = 0;
  logic line_drv = 1;
  logic tie = 0;
  logic line;
  logic fault_n, drive_off;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  assign line = tie ? fault_n : line_drv;

  ocp_fault_latch #(.DEB_CYC(DEB), .CLR_CYC(CLR), .SYNC_STAGES(STG)) uut (
    .clk(clk), .rst(rst), .trip_i(trip), .sync_i(sync_drv), .line_i(line),
    .fault_n_o(fault_n), .drive_off_o(drive_off));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_fault();
    trip = 1;
    tick(DEB);
  endtask

  task automatic do_clear();
    line_drv = 0;
    tick(CLR);
    line_drv = 1;
    tick(1);
  endtask

  task automatic t_reset();
    rst = 1; tick(3);
    chk("R1 fault_n in reset", fault_n, 1'b1);
    chk("R1 drive_off in reset", drive_off, 1'b0);
    rst = 0; tick(1);
    set_fault();
    chk("R1 latched before reset", fault_n, 1'b0);
    trip = 0; rst = 1; tick(1); rst = 0; tick(1);
    chk("R1 fault_n after reset", fault_n, 1'b1);
    chk("R1 drive_off after reset", drive_off, 1'b0);
  endtask

  task automatic t_debounce();
    trip = 1; tick(DEB - 1);
    chk("R2 not yet", fault_n, 1'b1);
    tick(1);
    chk("R2 latched", fault_n, 1'b0);
    chk("R5 drive_off on", drive_off, 1'b1);
    trip = 0; tick(10);
    chk("R4 held after trip drop", fault_n, 1'b0);
    line_drv = 0; tick(CLR - 1);
    chk("R6 before width", fault_n, 1'b0);
    tick(1);
    chk("R6 cleared", fault_n, 1'b1);
    chk("R5 drive_off off", drive_off, 1'b0);
    line_drv = 1; tick(1);
  endtask

  task automatic t_restart();
    trip = 1; tick(DEB - 1);
    trip = 0; tick(1);
    trip = 1; tick(DEB - 1);
    chk("R3 restarted count", fault_n, 1'b1);
    tick(1);
    chk("R3 latched after full run", fault_n, 1'b0);
    trip = 0; do_clear();
  endtask

  task automatic t_short_pulse();
    set_fault(); trip = 0;
    line_drv = 0; tick(CLR - 1); line_drv = 1; tick(3);
    chk("R6 short pulse ignored", fault_n, 1'b0);
    line_drv = 0; tick(CLR - 1); line_drv = 1; tick(3);
    chk("R6 second short pulse ignored", fault_n, 1'b0);
    do_clear();
    chk("R6 full pulse clears", fault_n, 1'b1);
  endtask

  task automatic t_idle_line();
    line_drv = 0; tick(CLR + 10);
    chk("R7 idle low line no fault", fault_n, 1'b1);
    chk("R7 idle low line no drive_off", drive_off, 1'b0);
    trip = 1; tick(DEB);
    chk("R7 latched with line low", fault_n, 1'b0);
    tick(CLR - 1);
    chk("R7 earlier lows not counted", fault_n, 1'b0);
    tick(1);
    chk("R7 clears after width from latch", fault_n, 1'b1);
    trip = 0; line_drv = 1; tick(2);
  endtask

  task automatic t_rearm();
    set_fault();
    do_clear();
    chk("R8 cleared with trip high", fault_n, 1'b1);
    tick(DEB + 20);
    chk("R8 no debounce relatch", fault_n, 1'b1);
    sync_drv = 1; tick(STG);
    chk("R8 rise not yet", fault_n, 1'b1);
    tick(1);
    chk("R8 relatch on rising sync", fault_n, 1'b0);
    do_clear();
    chk("R8 cleared again", fault_n, 1'b1);
    sync_drv = 0; tick(STG);
    chk("R8 fall not yet", fault_n, 1'b1);
    tick(1);
    chk("R8 relatch on falling sync", fault_n, 1'b0);
    trip = 0; do_clear();
    chk("R8 armed after final clear", fault_n, 1'b1);
  endtask

  task automatic t_cancel();
    set_fault();
    line_drv = 0; tick(CLR); line_drv = 1;
    trip = 0; tick(1);
    trip = 1; sync_drv = ~sync_drv; tick(STG + 1);
    chk("R9 cancelled, sync no relatch", fault_n, 1'b1);
    tick(DEB - STG - 2);
    chk("R9 full debounce needed", fault_n, 1'b1);
    tick(1);
    chk("R9 latched after debounce", fault_n, 1'b0);
    trip = 0; do_clear();
    sync_drv = ~sync_drv; tick(STG + 4);
    chk("R9 sync alone no fault", fault_n, 1'b1);
  endtask

  task automatic t_autoreset();
    tie = 1; trip = 1; tick(DEB);
    chk("R10 latched", fault_n, 1'b0);
    chk("R10 line pulled low", line, 1'b0);
    tick(CLR - 1);
    chk("R10 not yet cleared", fault_n, 1'b0);
    tick(1);
    chk("R10 auto cleared", fault_n, 1'b1);
    sync_drv = ~sync_drv; tick(STG + 1);
    chk("R10 relatch on sync", fault_n, 1'b0);
    tick(CLR);
    chk("R10 auto cleared again", fault_n, 1'b1);
    trip = 0; tick(2);
    sync_drv = ~sync_drv; tick(STG + 3);
    chk("R10 stays clear after overload", fault_n, 1'b1);
    tie = 0; tick(1);
  endtask

  initial begin
    t_reset();
    t_debounce();
    t_restart();
    t_short_pulse();
    t_idle_line();
    t_rearm();
    t_cancel();
    t_autoreset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule